// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host processor reach the management registers of an Ethernet PHY over the two-wire management interface: a clock line (MDC) and a bidirectional data line (MDIO). The host sees two 16-bit registers. One is a command register that packs the PHY address, the PHY register number, a clock-range code, a direction bit and a self-clearing busy/start bit. The other is a data register. To write, the host stages the value in the data register and then writes the command with the start bit set. To read, it writes the command and polls busy. When busy drops, the data register holds the value returned by the PHY.

The block derives MDC from the system clock through a divider chosen by the clock-range code. It shifts a Clause 22 frame out MSB-first, releases MDIO for the turnaround and data phases of a read, and samples the PHY's bits. A command written with the start bit clear sends no frame. It only runs a short burst of MDC periods, which wakes PHYs that need clock edges to finish their reset.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the command and data registers read 0, MDC is low and the MDIO output enable is low.
- R2: The host selects a register with `reg_sel`: 0 is the command register and 1 is the data register. Command bits are PHY address [15:11], register number [10:6], clock-range code [5:2], direction [1] (1 = write, 0 = read) and start/busy [0]. An accepted command with bit 0 set starts a frame. Bit 0 reads 1 until the frame ends and then reads 0. The other fields read back as written.
- R3: Clock-range codes 0, 1, 2, 3, 4 and 5 give MDC periods of 16, 26, 42, 62, 102 and 124 system clocks. Codes 6 to 15 use 124. MDC is high for half of each period. Busy reads 0 exactly 64 × period cycles after the clock edge that accepts the command.
- R4: A write frame is sent MSB-first as 32 ones, 01, 01, the PHY address, the register number, 10, and then the 16 staged data bits. MDIO is driven for all 64 bits.
- R5: A read frame sends 32 ones, 01, 10, the PHY address and the register number. MDIO is released for the last 18 bits. The 16 bits sampled from the PHY appear in the data register in the cycle in which busy reads 0.
- R6: The data register written while idle reads back the written value. A write frame sends the value staged before the command and leaves the data register unchanged.
- R7: While busy is 1, writes to either register are ignored and the running frame completes unchanged.
- R8: Within a frame, MDIO output changes only at the clock edge where MDC falls. PHY bits are sampled at the edge where MDC rises.
- R9: An accepted command with bit 0 clear stores its fields and produces 4 MDC periods at the rate of its clock-range code. It leaves MDIO released, does not set busy and does not change the data register.
- R10: A frame command accepted during such a burst ends the burst, restarts MDC from low, and runs with the timing and contents of R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 16 | Host write value |
| cmd_rdata | output | 16 | Command register contents |
| data_rdata | output | 16 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A register write takes effect at the clock edge that accepts it. The bench applies writes at a falling system-clock edge and reads both registers back at the next falling edge. After a frame command, the bench counts falling edges from the accepting edge until busy reads 0 and compares the count with 64 times the MDC period of the code used. The data register is checked at that same falling edge. A PHY model samples the MDIO line at falling system-clock edges after each MDC rise and presents read data after each MDC fall. Every frame bit, the output-enable mask and the edge at which the output changes are therefore judged away from the edges at which the design updates.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int PREAMBLE_BITS = 32;
  localparam int DATA_BITS     = 16;
  localparam int FRAME_BITS    = PREAMBLE_BITS + 32;
  localparam int SAMPLE_BIT    = FRAME_BITS - DATA_BITS;  // first PHY-driven data bit
  localparam int RELEASE_BIT   = SAMPLE_BIT - 2;          // turnaround start on reads
  localparam int HALF_W        = 6;
  localparam int CSR_W         = 4;
  localparam int ADDR_W        = 5;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regnum;
    logic [CSR_W-1:0]  csr;
    logic              wr;
    logic              go;
  } mdio_cmd_t;

  // Half of the MDC period in system clocks for each clock-range code.
  function automatic logic [HALF_W-1:0] half_period(input logic [CSR_W-1:0] code);
    case (code)
      4'd0:    half_period = 6'd8;
      4'd1:    half_period = 6'd13;
      4'd2:    half_period = 6'd21;
      4'd3:    half_period = 6'd31;
      4'd4:    half_period = 6'd51;
      default: half_period = 6'd62;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise_tick,
  output logic              fall_tick
);
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              mdc_d;
  logic              wrap;

  always_comb begin
    wrap      = run && !restart && (cnt_q == half - 1'b1);
    rise_tick = wrap && !mdc;
    fall_tick = wrap && mdc;
    cnt_d     = cnt_q;
    mdc_d     = mdc;
    if (restart || !run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc   <= mdc_d;
    end
  end

  // R3: MDC never runs while the block is idle.
  assert_mdc_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    phy,
  input  logic [ADDR_W-1:0]    regnum,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 active,
  output logic                 done,
  output logic [DATA_BITS-1:0] rdata
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX   = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] PRE_REL    = IW'(RELEASE_BIT - 1);
  localparam logic [IW-1:0] SAMPLE_IDX = IW'(SAMPLE_BIT);
  localparam logic [IW-1:0] REL_IDX    = IW'(RELEASE_BIT);

  logic [FRAME_BITS-1:0] sh_q, sh_d, frame;
  logic [IW-1:0]         idx_q, idx_d;
  logic                  act_q, act_d, wr_q, wr_d, oe_q, oe_d;
  logic [DATA_BITS-1:0]  rd_q, rd_d;

  always_comb begin
    frame = {{PREAMBLE_BITS{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, regnum,
             (wr ? 2'b10 : 2'b11), (wr ? wdata : {DATA_BITS{1'b1}})};
    sh_d  = sh_q;
    idx_d = idx_q;
    act_d = act_q;
    wr_d  = wr_q;
    oe_d  = oe_q;
    rd_d  = rd_q;
    done  = act_q && fall_tick && (idx_q == LAST_IDX);
    if (start) begin
      sh_d  = frame;
      idx_d = '0;
      act_d = 1'b1;
      wr_d  = wr;
      oe_d  = 1'b1;
    end else if (act_q) begin
      if (rise_tick && !wr_q && (idx_q >= SAMPLE_IDX)) begin
        rd_d = {rd_q[DATA_BITS-2:0], mdio_i};
      end
      if (fall_tick) begin
        if (idx_q == LAST_IDX) begin
          act_d = 1'b0;
          oe_d  = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
          if (!wr_q && (idx_q == PRE_REL)) oe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      idx_q <= '0;
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      oe_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
      act_q <= act_d;
      wr_q  <= wr_d;
      oe_q  <= oe_d;
      rd_q  <= rd_d;
    end
  end

  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = oe_q;
  assign active  = act_q;
  assign rdata   = rd_q;

  // R5: a read frame keeps MDIO released from the turnaround onwards.
  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !wr_q && (idx_q >= REL_IDX)) |-> !oe_q);
  // R4: a write frame drives MDIO for every bit.
  assert_write_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && wr_q) |-> oe_q);
endmodule

// File: rtl/mdio_host_regs.sv
`timescale 1ns/1ps
module mdio_host_regs
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic                 reg_sel,
  input  logic [15:0]          reg_wdata,
  input  logic                 frame_done,
  input  logic [DATA_BITS-1:0] rd_data,
  output mdio_cmd_t            cmd_q,
  output logic [DATA_BITS-1:0] data_q,
  output logic                 start,
  output logic                 wake_req
);
  mdio_cmd_t            cmd_d;
  logic [DATA_BITS-1:0] data_d;
  logic                 accept;

  always_comb begin
    accept   = reg_we && !cmd_q.go;
    start    = accept && !reg_sel && reg_wdata[0];
    wake_req = accept && !reg_sel && !reg_wdata[0];
    cmd_d    = cmd_q;
    data_d   = data_q;
    if (accept && !reg_sel) cmd_d  = mdio_cmd_t'(reg_wdata);
    if (accept && reg_sel)  data_d = reg_wdata;
    if (frame_done) begin
      cmd_d.go = 1'b0;
      if (!cmd_q.wr) data_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
    end
  end

  // R7: a running frame keeps its command and busy flag until it ends.
  assert_cmd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q.go && !frame_done) |=> (cmd_q.go &&
      $stable({cmd_q.phy, cmd_q.regnum, cmd_q.csr, cmd_q.wr})));
  // R7: the data register does not move while a frame runs.
  assert_data_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q.go && !frame_done) |=> $stable(data_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int WAKE_PERIODS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] cmd_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int WW = (WAKE_PERIODS > 1) ? $clog2(WAKE_PERIODS) : 1;
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_PERIODS - 1);

  logic [1:0]           rst_pipe;
  logic                 rst_n_s;
  mdio_cmd_t            cmd_q;
  logic [DATA_BITS-1:0] data_q, rd_data;
  logic                 start, wake_req, frame_done, sh_active;
  logic                 rise_tick, fall_tick, run, restart;
  logic                 wake_q, wake_d;
  logic [WW-1:0]        wcnt_q, wcnt_d;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  mdio_host_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .frame_done(frame_done), .rd_data(rd_data),
    .cmd_q(cmd_q), .data_q(data_q), .start(start), .wake_req(wake_req)
  );

  always_comb begin
    wake_d = wake_q;
    wcnt_d = wcnt_q;
    if (start) begin
      wake_d = 1'b0;
    end else if (wake_req) begin
      wake_d = 1'b1;
      wcnt_d = '0;
    end else if (wake_q && fall_tick) begin
      if (wcnt_q == WAKE_LAST) wake_d = 1'b0;
      else                     wcnt_d = wcnt_q + 1'b1;
    end
    run     = cmd_q.go || wake_q;
    restart = start || wake_req;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wake_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      wake_q <= wake_d;
      wcnt_q <= wcnt_d;
    end
  end

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n_s), .run(run), .restart(restart),
    .half(half_period(cmd_q.csr)), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst_n(rst_n_s), .start(start), .wr(reg_wdata[1]),
    .phy(reg_wdata[15:11]), .regnum(reg_wdata[10:6]), .wdata(data_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .active(sh_active),
    .done(frame_done), .rdata(rd_data)
  );

  assign cmd_rdata  = cmd_q;
  assign data_rdata = data_q;

  // R8: inside a frame the MDIO output moves only with a falling MDC.
  assert_mdio_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sh_active && $past(sh_active) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));
  // R2: MDIO is driven only while the busy flag is up.
  assert_oe_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    mdio_oe |-> cmd_q.go);
  // R9: the wake burst never drives MDIO.
  assert_wake_released_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    wake_q |-> !mdio_oe);
endmodule

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] cmd_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_in;
  logic        phy_drive;
  logic [15:0] resp;
  logic [63:0] cap, oecap;
  logic [6:0]  pcnt;
  logic        mdc_d, busy_d, mo_d;
  int          edge_viol;
  int          n_tests, n_fail;

  always #4 clk = ~clk;

  assign mdio_in = mdio_oe ? mdio_o : phy_drive;

  mdio_mgmt_master dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model, evaluated away from the active edge.
  always @(negedge clk) begin
    mdc_d  <= mdc;
    busy_d <= cmd_rdata[0];
    mo_d   <= mdio_o;
    if (!rst_n || !cmd_rdata[0]) begin
      pcnt      <= '0;
      phy_drive <= 1'b1;
    end else begin
      if (mdc && !mdc_d) begin
        cap   <= {cap[62:0], mdio_in};
        oecap <= {oecap[62:0], mdio_oe};
        pcnt  <= pcnt + 7'd1;
      end
      if (!mdc && mdc_d)
        phy_drive <= (pcnt >= 7'd48 && pcnt <= 7'd63) ? resp[6'd63 - pcnt[5:0]] : 1'b1;
      if (busy_d && (mdio_o != mo_d) && !(!mdc && mdc_d))
        edge_viol <= edge_viol + 1;
    end
  end

  // {wr, csr[3:0], phy[4:0], reg[4:0], 1'b0, data/response[15:0]}
  localparam logic [31:0] VEC [0:5] = '{
    {1'b1, 4'd0, 5'd1,  5'd0,  1'b0, 16'hA5C3},
    {1'b0, 4'd0, 5'd31, 5'd31, 1'b0, 16'h1234},
    {1'b1, 4'd1, 5'd10, 5'd5,  1'b0, 16'hFFFF},
    {1'b0, 4'd2, 5'd0,  5'd2,  1'b0, 16'h8001},
    {1'b0, 4'd9, 5'd3,  5'd17, 1'b0, 16'h0F0E},
    {1'b1, 4'd3, 5'd21, 5'd10, 1'b0, 16'h0000}
  };

  function automatic int exp_ratio(input logic [3:0] code);
    case (code)
      4'd0: return 16;
      4'd1: return 26;
      4'd2: return 42;
      4'd3: return 62;
      4'd4: return 102;
      default: return 124;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, (wr ? 2'b10 : 2'b11), d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [15:0] val);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (cmd_rdata[0] && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_frame(input logic [31:0] v, output bit all_ok);
    logic        wr;
    logic [3:0]  csr;
    logic [4:0]  phy, rg;
    logic [15:0] d;
    logic [63:0] oe_exp;
    int          n, f0;
    wr = v[31]; csr = v[30:27]; phy = v[26:22]; rg = v[21:17]; d = v[15:0];
    f0 = n_fail;
    if (wr) host_write(1'b1, d);
    else    resp = d;
    host_write(1'b0, {phy, rg, csr, wr, 1'b1});
    chk(cmd_rdata[0] == 1'b1, "R2 busy set after start", 64'(cmd_rdata), 64'(1));
    wait_idle(n);
    chk(n == 64 * exp_ratio(csr), "R3 frame length in clocks", 64'(n), 64'(64 * exp_ratio(csr)));
    chk(cap == exp_frame(wr, phy, rg, d), wr ? "R4 write frame bits" : "R5 read frame bits",
        cap, exp_frame(wr, phy, rg, d));
    oe_exp = wr ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
    chk(oecap == oe_exp, wr ? "R4 output enable" : "R5 release mask", oecap, oe_exp);
    chk(data_rdata == d, wr ? "R6 data kept after write" : "R5 read data captured",
        64'(data_rdata), 64'(d));
    chk(cmd_rdata == {phy, rg, csr, wr, 1'b0}, "R2 fields read back, busy cleared",
        64'(cmd_rdata), 64'({phy, rg, csr, wr, 1'b0}));
    all_ok = (n_fail == f0);
  endtask

  task automatic watch_mdc(input int cycles, output int rises, output int period,
                           output bit oe_seen, output bit busy_seen);
    logic prev;
    int   t1;
    prev = mdc; rises = 0; period = 0; t1 = 0; oe_seen = 0; busy_seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (mdc && !prev) begin
        rises++;
        if (rises == 1) t1 = i;
        if (rises == 2) period = i - t1;
      end
      if (mdio_oe) oe_seen = 1;
      if (cmd_rdata[0]) busy_seen = 1;
      prev = mdc;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int          rises, period, n;
    bit          oe_seen, busy_seen, ok;
    logic [15:0] d0;
    n_tests = 0; n_fail = 0; edge_viol = 0;
    resp = 16'h0; cap = '0; oecap = '0;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cmd_rdata == 16'h0, "R1 command reset", 64'(cmd_rdata), 64'(0));
    chk(data_rdata == 16'h0, "R1 data reset", 64'(data_rdata), 64'(0));
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc and oe low", 64'({mdc, mdio_oe}), 64'(0));

    // R6 idle data register write and read back
    host_write(1'b1, 16'h5A5A);
    chk(data_rdata == 16'h5A5A, "R6 data register write", 64'(data_rdata), 64'h5A5A);

    // Vector table: frames of both directions over several clock ranges
    for (int i = 0; i < 6; i++) run_frame(VEC[i], ok);

    // R7 commands and data writes during busy are ignored
    d0 = data_rdata;
    resp = 16'hBEEF;
    host_write(1'b0, {5'd5, 5'd9, 4'd2, 1'b0, 1'b1});
    repeat (300) @(negedge clk);
    host_write(1'b0, {5'd17, 5'd3, 4'd0, 1'b1, 1'b1});
    chk(cmd_rdata == {5'd5, 5'd9, 4'd2, 1'b0, 1'b1}, "R7 command ignored while busy",
        64'(cmd_rdata), 64'({5'd5, 5'd9, 4'd2, 1'b0, 1'b1}));
    host_write(1'b1, 16'h1111);
    chk(data_rdata == d0, "R7 data write ignored while busy", 64'(data_rdata), 64'(d0));
    wait_idle(n);
    chk(cap == exp_frame(1'b0, 5'd5, 5'd9, 16'hBEEF), "R7 frame intact",
        cap, exp_frame(1'b0, 5'd5, 5'd9, 16'hBEEF));
    chk(data_rdata == 16'hBEEF, "R7 read result intact", 64'(data_rdata), 64'hBEEF);

    // R9 wake burst, fastest clock range
    d0 = data_rdata;
    host_write(1'b0, 16'h0000);
    watch_mdc(600, rises, period, oe_seen, busy_seen);
    chk(rises == 4, "R9 wake burst periods", 64'(rises), 64'(4));
    chk(period == 16, "R9 wake period code 0", 64'(period), 64'(16));
    chk(!oe_seen && !busy_seen, "R9 no drive, no busy", 64'({oe_seen, busy_seen}), 64'(0));
    chk(data_rdata == d0, "R9 data untouched", 64'(data_rdata), 64'(d0));

    // R9 wake burst, slowest clock range; fields stored
    host_write(1'b0, 16'h0014);
    chk(cmd_rdata == 16'h0014, "R9 wake command stored", 64'(cmd_rdata), 64'h0014);
    watch_mdc(1200, rises, period, oe_seen, busy_seen);
    chk(rises == 4 && period == 124, "R9 wake at code 5", 64'({rises, period}), 64'({32'd4, 32'd124}));

    // R10 frame started in the middle of a wake burst
    host_write(1'b0, 16'h0000);
    repeat (20) @(negedge clk);
    run_frame({1'b1, 4'd2, 5'd12, 5'd7, 1'b0, 16'hC0DE}, ok);
    chk(ok, "R10 frame after wake preempt", 64'(ok), 64'(1));

    // R8 output changed only at MDC falling edges during all frames
    chk(edge_viol == 0, "R8 mdio changes at MDC fall", 64'(edge_viol), 64'(0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule